// File: doc/BRIEF.md
# Four-Channel Fly-By DMA Engine

This block moves bytes between two serial channels' FIFOs and memory without passing any data through itself. It has four channels: receive A, receive B, transmit A and transmit B. Each channel holds a 32-bit address counter and a 16-bit transfer counter, and a control bit sets whether its address counts up or down. A channel requests service when it is enabled, its count is not zero and its FIFO level line is high. For a receive FIFO the level line means that at least one byte is waiting. For a transmit FIFO it means that there is room.

When any channel requests, the engine raises a bus request and waits for the grant. It then serves one channel at a time. On each cycle of service it drives that channel's address and a one-hot acknowledge, and each such cycle is one byte moved directly between the FIFO and memory. A channel keeps the bus until its level line drops or its count runs out, even if a higher-priority channel starts to request. In hold mode the next pending channel then takes over without releasing the bus. In release mode the bus request drops after every channel and is raised again.

Top module: `fbdma_top`

## Requirements
- R1: After a synchronous active-low reset, `bus_req`, `dma_ack`, `tc_evt` and `abort_evt` are all zero, every channel is disabled and hold mode is selected.
- R2: A register write (`cfg_we`) with `cfg_sel` = 0 loads the address of channel `cfg_ch`, 1 loads its count from the low 16 bits, 2 loads control (bit0 enable, bit1 decrement), and 3 sets the bus mode (bit0 = 1 means release per channel). A channel whose request appears at a clock edge has `bus_req` high after that edge.
- R3: No acknowledge is driven unless `bus_req` and `bus_gnt` are both high. While the grant is held low, no transfer occurs.
- R4: `dma_ack` is one-hot or zero. Each acknowledge presents the serving channel's current address on `dma_addr`. After that, the address steps by +1, or by −1 when the decrement bit is set, wrapping modulo 2^32.
- R5: Each acknowledge lowers the channel's count by one. The acknowledge that takes the count to zero is followed, in the next cycle, by a one-cycle `tc_evt` pulse for that channel, and the channel becomes disabled.
- R6: A serving channel is never preempted. While its request stays high, no other channel is acknowledged, even if that channel has higher priority.
- R7: Channel indices give a fixed priority: 0 (Rx A) is highest, then 1 (Rx B), 2 (Tx A) and 3 (Tx B). In hold mode, when the serving channel stops, the highest-priority pending channel is served next and `bus_req` stays high throughout.
- R8: In release mode, `bus_req` drops for at least one cycle after each channel finishes, before the next channel is served.
- R9: Raising `chan_abort` for an enabled channel suppresses its acknowledge in that same cycle and disables the channel. It gives a one-cycle `abort_evt` in the next cycle and no `tc_evt`.
- R10: A channel that is disabled, or whose count is zero, makes no request, whatever its level line is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 2 | Channel index for the write |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 control, 3 bus mode |
| cfg_wdata | input | 32 | Write data |
| fifo_lvl | input | 4 | Per-channel FIFO level (data present for receive, room for transmit) |
| chan_abort | input | 4 | Per-channel abort |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| dma_addr | output | 32 | Transfer address |
| dma_ack | output | 4 | Per-channel transfer acknowledge, one byte per cycle |
| tc_evt | output | 4 | Terminal-count pulse per channel |
| abort_evt | output | 4 | Abort pulse per channel |

## Verification
The bench builds the block with its default parameters: four channels, a 32-bit address and a 16-bit count. Using the full 32-bit address lets start addresses just below the top and just above zero show the address wrapping in both directions. Counts of one to ten bring terminal count within a few cycles and let several channels finish inside one bus tenure, so priority order, non-preemption and the two bus modes can all be observed in short runs.

// File: rtl/fbdma_pkg.sv
// Package: shared types and register select codes for the fly-by DMA engine.
// Assumes: register selects are two bits wide.
package fbdma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_XFER = 2'd2
    } seq_state_t;

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_CNT  = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;
    localparam logic [1:0] SEL_MODE = 2'd3;
endpackage

// File: rtl/fbdma_chan.sv
// Module: one DMA channel. Holds the address and transfer counters and the
// enable and direction bits, and forms the channel's request.
// Assumes: step is only asserted while req is high, so abort and step never
// coincide.
module fbdma_chan #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_addr,
    input  logic          wr_cnt,
    input  logic          wr_ctrl,
    input  logic [AW-1:0] wdata,
    input  logic [CW-1:0] wcnt,
    input  logic [1:0]    wctrl,
    input  logic          lvl,
    input  logic          abort,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          req,
    output logic          tc_evt,
    output logic          ab_evt
);
    logic [CW-1:0] cnt;
    logic          en;
    logic          dec;

    // Request: enabled, count left, FIFO ready, not aborting.
    assign req = en && lvl && (cnt != '0) && !abort;

    // Address counter: load on write, step up or down per transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (wr_addr) begin
            addr <= wdata;
        end else if (step) begin
            addr <= dec ? addr - 1'b1 : addr + 1'b1;
        end
    end

    // Transfer counter: load on write, count down per transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (wr_cnt) begin
            cnt <= wcnt;
        end else if (step) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Control bits and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en     <= 1'b0;
            dec    <= 1'b0;
            tc_evt <= 1'b0;
            ab_evt <= 1'b0;
        end else begin
            tc_evt <= 1'b0;
            ab_evt <= 1'b0;
            if (abort) begin
                en     <= 1'b0;
                ab_evt <= en;
            end else if (wr_ctrl) begin
                en  <= wctrl[0];
                dec <= wctrl[1];
            end else if (step && cnt == CW'(1)) begin
                en     <= 1'b0;
                tc_evt <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/fbdma_arb.sv
// Module: fixed-priority picker; the lowest index wins.
// Assumes: purely combinational, evaluated every cycle.
module fbdma_arb #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          vld,
    output logic [IW-1:0] idx
);
    // Scan from lowest to highest priority so the last hit is the winner.
    always_comb begin
        vld = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                vld = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/fbdma_seq.sv
// Module: bus sequencer. Requests the bus, waits for the grant, serves one
// channel until its request drops, then either hands over or releases.
// Assumes: the grant may drop at any time; transfers pause while it is low.
module fbdma_seq
    import fbdma_pkg::*;
#(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          pick_vld,
    input  logic [IW-1:0] pick_idx,
    input  logic          rel_mode,
    input  logic          gnt,
    output logic          bus_req,
    output logic [IW-1:0] cur,
    output logic [N-1:0]  step
);
    seq_state_t st;

    // State and serving-channel register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cur <= '0;
        end else begin
            case (st)
                ST_IDLE: if (pick_vld) st <= ST_REQ;
                ST_REQ: if (gnt) begin
                    if (pick_vld) begin
                        st  <= ST_XFER;
                        cur <= pick_idx;
                    end else begin
                        st <= ST_IDLE;
                    end
                end
                ST_XFER: if (!req[cur]) begin
                    if (!rel_mode && pick_vld) cur <= pick_idx;
                    else                       st  <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign bus_req = (st != ST_IDLE);

    // One transfer per cycle for the serving channel while granted.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            step[i] = (st == ST_XFER) && gnt && req[i] && (cur == IW'(i));
        end
    end
endmodule

// File: rtl/fbdma_top.sv
// Module: four-channel fly-by DMA engine top. Decodes register writes,
// instantiates the channels, the priority picker and the bus sequencer, and
// drives the address of the serving channel.
// Assumes: index 0 is the highest priority.
module fbdma_top
    import fbdma_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 32,
    parameter int CW  = 16,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [IW-1:0]  cfg_ch,
    input  logic [1:0]     cfg_sel,
    input  logic [AW-1:0]  cfg_wdata,
    input  logic [NCH-1:0] fifo_lvl,
    input  logic [NCH-1:0] chan_abort,
    output logic           bus_req,
    input  logic           bus_gnt,
    output logic [AW-1:0]  dma_addr,
    output logic [NCH-1:0] dma_ack,
    output logic [NCH-1:0] tc_evt,
    output logic [NCH-1:0] abort_evt
);
    logic [NCH-1:0] ch_req;
    logic [AW-1:0]  ch_addr [NCH];
    logic           rel_mode;
    logic           pick_vld;
    logic [IW-1:0]  pick_idx;
    logic [IW-1:0]  cur;

    // Bus mode register: hold or release per channel.
    always_ff @(posedge clk) begin
        if (!rst_n)                             rel_mode <= 1'b0;
        else if (cfg_we && cfg_sel == SEL_MODE) rel_mode <= cfg_wdata[0];
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic sel_me;
        assign sel_me = cfg_we && (cfg_ch == IW'(g));
        fbdma_chan #(.AW(AW), .CW(CW)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_addr(sel_me && cfg_sel == SEL_ADDR),
            .wr_cnt (sel_me && cfg_sel == SEL_CNT),
            .wr_ctrl(sel_me && cfg_sel == SEL_CTRL),
            .wdata  (cfg_wdata),
            .wcnt   (cfg_wdata[CW-1:0]),
            .wctrl  (cfg_wdata[1:0]),
            .lvl    (fifo_lvl[g]),
            .abort  (chan_abort[g]),
            .step   (dma_ack[g]),
            .addr   (ch_addr[g]),
            .req    (ch_req[g]),
            .tc_evt (tc_evt[g]),
            .ab_evt (abort_evt[g])
        );
    end

    fbdma_arb #(.N(NCH)) u_arb (
        .req(ch_req),
        .vld(pick_vld),
        .idx(pick_idx)
    );

    fbdma_seq #(.N(NCH)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (ch_req),
        .pick_vld(pick_vld),
        .pick_idx(pick_idx),
        .rel_mode(rel_mode),
        .gnt     (bus_gnt),
        .bus_req (bus_req),
        .cur     (cur),
        .step    (dma_ack)
    );

    assign dma_addr = ch_addr[cur];
endmodule

// File: rtl/fbdma_chk.sv
// Module: protocol checker for fbdma_top, attached by bind.
// Assumes: reset is held for at least one clock edge.
module fbdma_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_req,
    input logic         bus_gnt,
    input logic [N-1:0] dma_ack,
    input logic [N-1:0] tc_evt,
    input logic [N-1:0] abort_evt,
    input logic [N-1:0] chan_abort
);
    a_r3_ack_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (|dma_ack) |-> (bus_req && bus_gnt));

    a_r4_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dma_ack));

    a_r6_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
        ((|dma_ack) && (|$past(dma_ack))) |-> (dma_ack == $past(dma_ack)));

    a_r5_tc_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (|tc_evt) |-> ((tc_evt & ~$past(dma_ack)) == '0));

    a_r9_abort_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        (|abort_evt) |-> ((abort_evt & ~$past(chan_abort)) == '0));

    a_r9_abort_blocks_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (|chan_abort) |-> ((chan_abort & dma_ack) == '0));
endmodule

bind fbdma_top fbdma_chk #(.N(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .dma_ack   (dma_ack),
    .tc_evt    (tc_evt),
    .abort_evt (abort_evt),
    .chan_abort(chan_abort)
);

// File: tb/fbdma_top_test.sv
module fbdma_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_ch = '0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  fifo_lvl = '0;
    logic [3:0]  chan_abort = '0;
    logic        bus_req;
    logic        bus_gnt;
    logic [31:0] dma_addr;
    logic [3:0]  dma_ack;
    logic [3:0]  tc_evt;
    logic [3:0]  abort_evt;

    logic auto_gnt = 1'b1;
    logic gnt_q = 1'b0;
    logic mon_clr = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fbdma_top uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .fifo_lvl(fifo_lvl),
        .chan_abort(chan_abort), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .dma_addr(dma_addr), .dma_ack(dma_ack), .tc_evt(tc_evt),
        .abort_evt(abort_evt)
    );

    // Arbiter model: grant one cycle after the request.
    always @(posedge clk) begin
        #1;
        gnt_q = bus_req;
    end
    assign bus_gnt = auto_gnt && gnt_q;

    // Monitor: counts acknowledges and events, checks every address.
    int          acks [4];
    int          tcs [4];
    int          abts [4];
    logic [31:0] exp_addr [4];
    logic [31:0] last_addr [4];
    logic        dec_bit [4];
    int          seq [16];
    int          seq_n;
    int          last_ch;
    int          falls;
    logic        prev_breq;
    int          mchk = 0;
    int          merr = 0;

    always @(negedge clk) begin
        if (cfg_we && cfg_sel == 2'd0) exp_addr[cfg_ch] = cfg_wdata;
        if (cfg_we && cfg_sel == 2'd2) dec_bit[cfg_ch] = cfg_wdata[1];
        if (mon_clr || !rst_n) begin
            for (int i = 0; i < 4; i++) begin
                acks[i] = 0; tcs[i] = 0; abts[i] = 0;
            end
            seq_n = 0; last_ch = -1; falls = 0; prev_breq = 1'b0;
        end else begin
            for (int i = 0; i < 4; i++) begin
                if (dma_ack[i]) begin
                    acks[i]++;
                    mchk++;
                    if (dma_addr !== exp_addr[i]) begin
                        merr++;
                        $display("FAIL R4 ch%0d address actual %h expected %h",
                                 i, dma_addr, exp_addr[i]);
                    end
                    last_addr[i] = dma_addr;
                    exp_addr[i] = dec_bit[i] ? exp_addr[i] - 1 : exp_addr[i] + 1;
                    if (i != last_ch && seq_n < 16) begin
                        seq[seq_n] = i; seq_n++; last_ch = i;
                    end
                end
                if (tc_evt[i])    tcs[i]++;
                if (abort_evt[i]) abts[i]++;
            end
            if (prev_breq && !bus_req) falls++;
            prev_breq = bus_req;
        end
    end

    int nchk = 0;
    int nerr = 0;
    logic done = 1'b0;

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input int ch, input int sel, input logic [31:0] d);
        cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 2'(sel); cfg_wdata = d;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input int ch, input logic [31:0] a, input int cnt, input logic dec);
        wr(ch, 0, a);
        wr(ch, 1, 32'(cnt));
        wr(ch, 2, {30'd0, dec, 1'b1});
    endtask

    task automatic do_reset();
        rst_n = 1'b0; fifo_lvl = '0; chan_abort = '0; auto_gnt = 1'b1;
        tick(3);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic wait_tc(input int ch, input int lim);
        for (int k = 0; k < lim && tcs[ch] == 0; k++) tick(1);
    endtask

    typedef struct packed {
        logic [1:0]  ch;
        logic        dec;
        logic [31:0] addr;
        logic [15:0] cnt;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{2'd0, 1'b0, 32'h1000_0000, 16'd3},
        '{2'd1, 1'b1, 32'h0000_0002, 16'd4},
        '{2'd2, 1'b0, 32'hFFFF_FFFE, 16'd3},
        '{2'd3, 1'b1, 32'h0000_8000, 16'd1},
        '{2'd0, 1'b1, 32'hABCD_0005, 16'd6}
    };

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog expired actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", nchk + mchk, nerr + merr);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        check(bus_req == 1'b0, "R1 bus_req after reset", int'(bus_req), 0);
        check(dma_ack == '0, "R1 ack after reset", int'(dma_ack), 0);
        check(tc_evt == '0 && abort_evt == '0, "R1 events after reset",
              int'({tc_evt, abort_evt}), 0);

        // R4 R5: table of single-channel runs to terminal count
        foreach (VECS[v]) begin
            automatic int ch = int'(VECS[v].ch);
            automatic logic [31:0] last_exp;
            do_reset();
            setup(ch, VECS[v].addr, int'(VECS[v].cnt), VECS[v].dec);
            fifo_lvl[ch] = 1'b1;
            wait_tc(ch, 200);
            tick(2);
            fifo_lvl = '0;
            last_exp = VECS[v].dec ? VECS[v].addr - 32'(VECS[v].cnt - 1)
                                   : VECS[v].addr + 32'(VECS[v].cnt - 1);
            check(acks[ch] == int'(VECS[v].cnt), "R5 ack count", acks[ch], int'(VECS[v].cnt));
            check(tcs[ch] == 1, "R5 tc pulse count", tcs[ch], 1);
            check(last_addr[ch] == last_exp, "R4 last address",
                  int'(last_addr[ch]), int'(last_exp));
            check(bus_req == 1'b0, "R5 bus released after tc", int'(bus_req), 0);
        end

        // R10: disabled channel and zero count make no request
        do_reset();
        wr(1, 0, 32'h100); wr(1, 1, 32'd5);
        fifo_lvl[1] = 1'b1;
        tick(6);
        check(bus_req == 1'b0 && acks[1] == 0, "R10 disabled channel", acks[1], 0);
        do_reset();
        wr(2, 1, 32'd0); wr(2, 2, 32'd1);
        fifo_lvl[2] = 1'b1;
        tick(6);
        check(bus_req == 1'b0 && acks[2] == 0, "R10 zero count", int'(bus_req), 0);

        // R2 R3: request rises, no transfer until grant
        do_reset();
        auto_gnt = 1'b0;
        setup(2, 32'h40, 2, 1'b0);
        fifo_lvl[2] = 1'b1;
        tick(6);
        check(bus_req == 1'b1, "R2 bus_req raised", int'(bus_req), 1);
        check(acks[2] == 0, "R3 no ack without grant", acks[2], 0);
        auto_gnt = 1'b1;
        wait_tc(2, 50);
        check(acks[2] == 2, "R3 transfers after grant", acks[2], 2);

        // R6: higher-priority request does not preempt
        do_reset();
        setup(3, 32'h300, 10, 1'b0);
        fifo_lvl[3] = 1'b1;
        for (int k = 0; k < 50 && acks[3] < 2; k++) tick(1);
        setup(0, 32'h000, 3, 1'b0);
        fifo_lvl[0] = 1'b1;
        tick(3);
        check(acks[0] == 0, "R6 no preemption", acks[0], 0);
        fifo_lvl[3] = 1'b0;
        wait_tc(0, 50);
        check(seq_n == 2 && seq[0] == 3 && seq[1] == 0, "R6 service order", seq[0], 3);
        check(acks[0] == 3, "R6 waiting channel served", acks[0], 3);

        // R7: hold mode, fixed priority, bus held throughout
        do_reset();
        setup(3, 32'h30, 2, 1'b0);
        setup(2, 32'h20, 2, 1'b0);
        setup(1, 32'h10, 2, 1'b0);
        fifo_lvl = 4'b1110;
        wait_tc(3, 100);
        tick(3);
        check(seq_n == 3 && seq[0] == 1 && seq[1] == 2 && seq[2] == 3,
              "R7 priority order", seq_n, 3);
        check(falls == 1, "R7 bus held across channels", falls, 1);

        // R8: release mode drops bus between channels
        do_reset();
        wr(0, 3, 32'd1);
        setup(2, 32'h20, 2, 1'b0);
        setup(0, 32'h00, 2, 1'b0);
        fifo_lvl = 4'b0101;
        wait_tc(2, 100);
        tick(3);
        check(seq_n == 2 && seq[0] == 0 && seq[1] == 2, "R8 order in release mode", seq[0], 0);
        check(falls == 2, "R8 bus released per channel", falls, 2);

        // R9: abort stops the channel at once
        do_reset();
        setup(1, 32'h500, 8, 1'b0);
        fifo_lvl[1] = 1'b1;
        for (int k = 0; k < 50 && acks[1] < 2; k++) tick(1);
        begin
            automatic int a0;
            chan_abort[1] = 1'b1;
            tick(1);
            chan_abort[1] = 1'b0;
            a0 = acks[1];
            tick(6);
            check(acks[1] == a0, "R9 no ack after abort", acks[1], a0);
            check(abts[1] == 1, "R9 abort event", abts[1], 1);
            check(tcs[1] == 0, "R9 no tc on abort", tcs[1], 0);
            check(bus_req == 1'b0, "R9 request dropped", int'(bus_req), 0);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", nchk + mchk, nerr + merr);
        $finish;
    end
endmodule